// File: doc/BRIEF.md
# Exception Priority Arbiter

This block picks which of 62 exception sources the processor should service next. Eight slots are traps. Their priorities are fixed, from 8 to 15, so a trap always outranks an interrupt. The other 54 slots are interrupts. Each interrupt has an enable bit and a 3-bit priority set by software, from 1 to 7. Sources raise a one-cycle request that sets an internal pending bit. The block registers the enables and priorities, finds the winning source, and presents its vector number and priority. It asserts a take signal when the winner's priority is strictly above the current processor level.

The block also keeps the current processor level. When the processor accepts a presented exception with the acknowledge input, the old level is saved on a 16-entry stack and the winner's priority becomes the new level. The winner's pending bit is cleared at the same time. A return input restores the saved level, so handlers can nest. Fetching the vector table, saving context and the processor itself are outside this block.

Top module: `exc_prioritizer`

## Requirements
- R1: Trap slot t (0..7) is reported as vector t. Interrupt line j (0..53) is reported as vector 8+j.
- R2: Trap slot t has fixed priority 15-t. Trap slots 4 to 7 are reserved, and raising them has no effect.
- R3: The priority of interrupt j is `irq_prio[3j+2:3j]`. An interrupt whose enable bit is 0, or whose priority is 0, never competes.
- R4: The pending source with the highest priority wins. Among sources of equal priority, the lowest vector number wins.
- R5: `take_o` is 1 only when the winner's priority is strictly greater than `cpu_lvl_o`.
- R6: The outputs are registered. A request raised before clock edge k first shows on `vec_o`, `prio_o` and `take_o` after edge k+1.
- R7: An acknowledge while `take_o` is 1 does four things at the next edge: it saves the old level, sets `cpu_lvl_o` to `prio_o`, clears the winner's pending bit, and forces `take_o` to 0 for one cycle.
- R8: An acknowledge while `take_o` is 0 has no effect.
- R9: A return restores the most recently saved level. A return with nothing saved has no effect. If acknowledge and return are both valid in the same cycle, the acknowledge is served.
- R10: The level stack never holds more than 16 entries.
- R11: After reset, nothing is pending, `cpu_lvl_o` is 0, `take_o` is 0, and `vec_o` and `prio_o` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_raise | input | 8 | One-cycle set pulses for the trap slots |
| irq_raise | input | 54 | One-cycle set pulses for the interrupt lines |
| irq_en | input | 54 | Interrupt enable bits |
| irq_prio | input | 162 | 3-bit priority for each interrupt, packed |
| ack | input | 1 | The processor accepts the presented exception |
| ret | input | 1 | The processor returns from a handler |
| vec_o | output | 6 | Vector number of the winning source |
| prio_o | output | 4 | Priority of the winner (0 when nothing competes) |
| take_o | output | 1 | The winner outranks the current level |
| cpu_lvl_o | output | 4 | Current processor priority level |

## Verification
A pending bit that is wrongly cleared or kept would show as the wrong `vec_o` two edges after the stimulus. A pending bit left set after acknowledge would reappear as soon as the level drops again. A corrupted level or stack entry would show at once on `cpu_lvl_o` after a return. It would also show as a wrong `take_o` on the next cycle. The checks therefore cover three cases: the winner after every change of requests, enables or priorities; the level after every acknowledge or return; and the take decision when the winner's priority equals the level exactly.

// File: rtl/exc_pkg.sv
// Shared types for the exception priority arbiter.
// Assumes at most 8 trap slots, so that 15-t stays at or above 8.
package exc_pkg;
    typedef logic [3:0] lvl_t;
    localparam int IRQ_PW = 3;
endpackage

// File: rtl/exc_pend_regs.sv
// Pending bits for traps and interrupts, plus registered copies of the
// interrupt enables and priorities. A raise pulse sets a pending bit. A clear
// request naming that vector resets it, and a raise in the same cycle wins.
// Reserved trap slots are tied to zero.
module exc_pend_regs
    import exc_pkg::*;
#(
    parameter int                     NUM_TRAPS = 8,
    parameter int                     NUM_IRQS  = 54,
    parameter logic [NUM_TRAPS-1:0]   TRAP_RSVD = 8'hF0,
    localparam int                    VEC_W     = $clog2(NUM_TRAPS + NUM_IRQS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_TRAPS-1:0]         trap_raise,
    input  logic [NUM_IRQS-1:0]          irq_raise,
    input  logic [NUM_IRQS-1:0]          irq_en_in,
    input  logic [NUM_IRQS*IRQ_PW-1:0]   irq_prio_in,
    input  logic                         clr_valid,
    input  logic [VEC_W-1:0]             clr_vec,
    output logic [NUM_TRAPS-1:0]         trap_pend,
    output logic [NUM_IRQS-1:0]          irq_pend,
    output logic [NUM_IRQS-1:0]          irq_en_q,
    output logic [NUM_IRQS*IRQ_PW-1:0]   irq_prio_q
);
    // Raise pulses on reserved slots go nowhere.
    logic rsvd_unused;
    assign rsvd_unused = ^(trap_raise & TRAP_RSVD);

    for (genvar t = 0; t < NUM_TRAPS; t++) begin : g_trap
        if (TRAP_RSVD[t]) begin : g_rsvd
            assign trap_pend[t] = 1'b0;
        end else begin : g_live
            logic pend_q;
            // Set on raise, clear on acknowledge of this vector.
            always_ff @(posedge clk) begin
                if (!rst_n)                                      pend_q <= 1'b0;
                else if (trap_raise[t])                          pend_q <= 1'b1;
                else if (clr_valid && clr_vec == VEC_W'(t))      pend_q <= 1'b0;
            end
            assign trap_pend[t] = pend_q;
        end
    end

    for (genvar j = 0; j < NUM_IRQS; j++) begin : g_irq
        // Set on raise, clear on acknowledge of this vector.
        always_ff @(posedge clk) begin
            if (!rst_n)                                              irq_pend[j] <= 1'b0;
            else if (irq_raise[j])                                   irq_pend[j] <= 1'b1;
            else if (clr_valid && clr_vec == VEC_W'(NUM_TRAPS + j))  irq_pend[j] <= 1'b0;
        end
    end

    // Register the software-written enables and priorities.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en_q   <= '0;
            irq_prio_q <= '0;
        end else begin
            irq_en_q   <= irq_en_in;
            irq_prio_q <= irq_prio_in;
        end
    end
endmodule

// File: rtl/exc_arbiter.sv
// Combinational winner search. Traps get priority 15-t. An interrupt competes
// only when it is enabled and its priority field is non-zero. The scan runs
// from the highest vector down with >=, so the lowest vector wins a tie.
// Assumes NUM_TRAPS <= 8. prio 0 on the output means nothing competes.
module exc_arbiter
    import exc_pkg::*;
#(
    parameter int  NUM_TRAPS = 8,
    parameter int  NUM_IRQS  = 54,
    localparam int VEC_W     = $clog2(NUM_TRAPS + NUM_IRQS)
) (
    input  logic [NUM_TRAPS-1:0]         trap_pend,
    input  logic [NUM_IRQS-1:0]          irq_pend,
    input  logic [NUM_IRQS-1:0]          irq_en,
    input  logic [NUM_IRQS*IRQ_PW-1:0]   irq_prio,
    output logic [VEC_W-1:0]             win_vec,
    output lvl_t                         win_prio
);
    // Scan all sources and keep the best priority, with lowest vector on ties.
    always_comb begin
        lvl_t cand;
        win_vec  = '0;
        win_prio = '0;
        for (int i = NUM_IRQS - 1; i >= 0; i--) begin
            cand = (irq_pend[i] && irq_en[i]) ? lvl_t'(irq_prio[IRQ_PW*i +: IRQ_PW]) : '0;
            if (cand != '0 && cand >= win_prio) begin
                win_prio = cand;
                win_vec  = VEC_W'(NUM_TRAPS + i);
            end
        end
        for (int t = NUM_TRAPS - 1; t >= 0; t--) begin
            if (trap_pend[t] && lvl_t'(15 - t) >= win_prio) begin
                win_prio = lvl_t'(15 - t);
                win_vec  = VEC_W'(t);
            end
        end
    end
endmodule

// File: rtl/exc_lvl_stack.sv
// LIFO of saved processor levels. A push writes at the current depth. A pop
// exposes the entry below. A pop on an empty stack is ignored. Assumes the
// caller never pushes into a full stack; the assertion below guards that.
module exc_lvl_stack
    import exc_pkg::*;
#(
    parameter int  DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic pop,
    input  lvl_t push_lvl,
    output lvl_t top_lvl,
    output logic empty
);
    localparam logic [PTR_W-1:0] FULL = PTR_W'(DEPTH);

    lvl_t             mem [DEPTH];
    logic [PTR_W-1:0] depth_q;
    logic [PTR_W-1:0] top_idx;

    assign top_idx = depth_q - PTR_W'(1);
    assign top_lvl = mem[top_idx[IDX_W-1:0]];
    assign empty   = (depth_q == '0);

    // Track how many levels are saved.
    always_ff @(posedge clk) begin
        if (!rst_n)                depth_q <= '0;
        else if (push)             depth_q <= depth_q + PTR_W'(1);
        else if (pop && !empty)    depth_q <= top_idx;
    end

    // Store the pushed level in the next free slot.
    always_ff @(posedge clk) begin
        if (push && depth_q < FULL) mem[depth_q[IDX_W-1:0]] <= push_lvl;
    end

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> depth_q < FULL);
endmodule

// File: rtl/exc_prioritizer.sv
// Top of the exception priority arbiter. Holds the processor level,
// registers the winner into vec_o/prio_o/take_o, and runs the acknowledge
// and return handshake. take_o is held low for one cycle after any level
// change, so a stale winner cannot be acknowledged twice.
module exc_prioritizer
    import exc_pkg::*;
#(
    parameter int                    NUM_TRAPS = 8,
    parameter int                    NUM_IRQS  = 54,
    parameter int                    STK_DEPTH = 16,
    parameter logic [NUM_TRAPS-1:0]  TRAP_RSVD = 8'hF0,
    localparam int                   VEC_W     = $clog2(NUM_TRAPS + NUM_IRQS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_TRAPS-1:0]          trap_raise,
    input  logic [NUM_IRQS-1:0]           irq_raise,
    input  logic [NUM_IRQS-1:0]           irq_en,
    input  logic [NUM_IRQS*IRQ_PW-1:0]    irq_prio,
    input  logic                          ack,
    input  logic                          ret,
    output logic [VEC_W-1:0]              vec_o,
    output logic [3:0]                    prio_o,
    output logic                          take_o,
    output logic [3:0]                    cpu_lvl_o
);
    logic [NUM_TRAPS-1:0]        trap_pend;
    logic [NUM_IRQS-1:0]         irq_pend;
    logic [NUM_IRQS-1:0]         irq_en_q;
    logic [NUM_IRQS*IRQ_PW-1:0]  irq_prio_q;
    logic [VEC_W-1:0]            win_vec;
    lvl_t                        win_prio;
    lvl_t                        cpu_lvl;
    lvl_t                        stk_top;
    logic                        stk_empty;
    logic                        do_ack;
    logic                        do_ret;

    assign do_ack    = ack && take_o;
    assign do_ret    = ret && !do_ack && !stk_empty;
    assign cpu_lvl_o = cpu_lvl;

    exc_pend_regs #(.NUM_TRAPS(NUM_TRAPS), .NUM_IRQS(NUM_IRQS), .TRAP_RSVD(TRAP_RSVD)) u_pend (
        .clk(clk), .rst_n(rst_n), .trap_raise(trap_raise), .irq_raise(irq_raise),
        .irq_en_in(irq_en), .irq_prio_in(irq_prio), .clr_valid(do_ack), .clr_vec(vec_o),
        .trap_pend(trap_pend), .irq_pend(irq_pend), .irq_en_q(irq_en_q), .irq_prio_q(irq_prio_q)
    );

    exc_arbiter #(.NUM_TRAPS(NUM_TRAPS), .NUM_IRQS(NUM_IRQS)) u_arb (
        .trap_pend(trap_pend), .irq_pend(irq_pend), .irq_en(irq_en_q), .irq_prio(irq_prio_q),
        .win_vec(win_vec), .win_prio(win_prio)
    );

    exc_lvl_stack #(.DEPTH(STK_DEPTH)) u_stk (
        .clk(clk), .rst_n(rst_n), .push(do_ack), .pop(do_ret), .push_lvl(cpu_lvl),
        .top_lvl(stk_top), .empty(stk_empty)
    );

    // Raise the level on acknowledge and restore it on return.
    always_ff @(posedge clk) begin
        if (!rst_n)      cpu_lvl <= '0;
        else if (do_ack) cpu_lvl <= prio_o;
        else if (do_ret) cpu_lvl <= stk_top;
    end

    // Register the winner and the take decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_o  <= '0;
            prio_o <= '0;
            take_o <= 1'b0;
        end else begin
            vec_o  <= win_vec;
            prio_o <= win_prio;
            take_o <= !(do_ack || do_ret) && (win_prio > cpu_lvl);
        end
    end

    // R5
    take_gt_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> prio_o > cpu_lvl);
    // R7
    ack_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_ack |=> (cpu_lvl == $past(prio_o)) && !take_o);
    // R8
    ack_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !take_o && !ret) |=> $stable(cpu_lvl));
    // R9
    ret_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_ret |=> cpu_lvl < $past(cpu_lvl));
    // R2
    trap_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_o > 4'd7) |-> (vec_o < VEC_W'(NUM_TRAPS)));
endmodule

// File: tb/test_exc_prioritizer.sv
`timescale 1ns/1ps
module test_exc_prioritizer;
    localparam int NT = 8;
    localparam int NI = 54;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NT-1:0]  trap_raise = '0;
    logic [NI-1:0]  irq_raise = '0;
    logic [NI-1:0]  irq_en = '0;
    logic [NI*3-1:0] irq_prio = '0;
    logic           ack = 1'b0;
    logic           ret = 1'b0;
    logic [5:0]     vec_o;
    logic [3:0]     prio_o;
    logic           take_o;
    logic [3:0]     cpu_lvl_o;

    always #2 clk = ~clk;

    exc_prioritizer i_exc_prioritizer (
        .clk(clk), .rst_n(rst_n), .trap_raise(trap_raise), .irq_raise(irq_raise),
        .irq_en(irq_en), .irq_prio(irq_prio), .ack(ack), .ret(ret),
        .vec_o(vec_o), .prio_o(prio_o), .take_o(take_o), .cpu_lvl_o(cpu_lvl_o)
    );

    typedef struct {
        int    vec;
        int    prio;
        bit    take;
        int    lvl;
        string req;
    } exp_t;

    exp_t  sb[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 0;
    event  chk_ev;

    // Bench model built from the requirements.
    bit    m_trap [NT];
    bit    m_irq  [NI];
    int    m_lvl = 0;
    int    m_stk[$];

    function automatic void best(output int v, output int p);
        v = 0; p = 0;
        for (int t = 0; t < NT; t++)
            if (m_trap[t] && (15 - t) > p) begin p = 15 - t; v = t; end
        for (int j = 0; j < NI; j++)
            if (m_irq[j] && irq_en[j] && int'(irq_prio[3*j +: 3]) > p) begin
                p = int'(irq_prio[3*j +: 3]); v = 8 + j;
            end
    endfunction

    // Driver side: push what the ports should show now.
    task automatic expect_now(input string req, input bit take_forced_low = 0);
        exp_t e;
        int v, p;
        best(v, p);
        e.vec = v; e.prio = p; e.lvl = m_lvl; e.req = req;
        e.take = !take_forced_low && (p > m_lvl);
        sb.push_back(e);
        -> chk_ev;
        #0;
    endtask

    // Monitor: compare each expected item against the ports.
    initial forever begin
        exp_t e;
        @(chk_ev);
        while (sb.size() > 0) begin
            e = sb.pop_front();
            n_chk++;
            if (int'(vec_o) != e.vec || int'(prio_o) != e.prio ||
                take_o != e.take || int'(cpu_lvl_o) != e.lvl) begin
                n_bad++;
                $display("FAIL %s: vec/prio/take/lvl got %0d/%0d/%0d/%0d exp %0d/%0d/%0d/%0d",
                         e.req, vec_o, prio_o, take_o, cpu_lvl_o, e.vec, e.prio, e.take, e.lvl);
            end
        end
    end

    // Wait two edges after a stimulus set at a negedge, then check.
    task automatic settle(input string req);
        @(negedge clk);
        trap_raise = '0; irq_raise = '0; ack = 1'b0; ret = 1'b0;
        @(negedge clk);
        expect_now(req);
    endtask

    task automatic cfg_irq(input int j, input bit en, input int p);
        irq_en[j] = en;
        irq_prio[3*j +: 3] = 3'(p);
    endtask

    task automatic raise_irq(input int j, input string req);
        irq_raise[j] = 1'b1;
        m_irq[j] = 1'b1;
        settle(req);
    endtask

    task automatic raise_trap(input int t, input string req);
        trap_raise[t] = 1'b1;
        if (t < 4) m_trap[t] = 1'b1;
        settle(req);
    endtask

    task automatic do_ack(input string req);
        int v, p;
        best(v, p);
        if (p > m_lvl) begin
            m_stk.push_back(m_lvl);
            m_lvl = p;
            if (v < NT) m_trap[v] = 1'b0; else m_irq[v-NT] = 1'b0;
        end
        ack = 1'b1;
        settle(req);
    endtask

    task automatic do_ret(input string req);
        if (m_stk.size() > 0) m_lvl = m_stk.pop_back();
        ret = 1'b1;
        settle(req);
    endtask

    initial begin
        for (int i = 0; i < NT; i++) m_trap[i] = 0;
        for (int i = 0; i < NI; i++) m_irq[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_now("R11 reset state");

        // R6: one edge after the raise, outputs still show the old state.
        cfg_irq(10, 1, 3);
        irq_raise[10] = 1'b1;
        @(negedge clk);
        irq_raise = '0;
        expect_now("R6 not visible after one edge");
        m_irq[10] = 1'b1;
        @(negedge clk);
        expect_now("R6 R1 R3 irq10 visible after two edges");

        cfg_irq(3, 1, 3);
        raise_irq(3, "R4 equal priority lowest vector");
        cfg_irq(40, 1, 6);
        raise_irq(40, "R4 higher priority wins");
        cfg_irq(41, 0, 7);
        raise_irq(41, "R3 disabled irq ignored");
        cfg_irq(42, 1, 0);
        raise_irq(42, "R3 zero priority ignored");
        raise_trap(3, "R2 R1 trap3 beats irq");
        raise_trap(1, "R2 trap1 beats trap3");
        raise_trap(5, "R2 reserved trap ignored");

        do_ack("R7 ack trap1 level 14");
        ack = 1'b1;
        settle("R8 ack without take ignored");
        do_ret("R9 return restores level 0");
        do_ack("R7 ack trap3 level 12");
        do_ret("R9 return to 0 again");
        do_ack("R7 ack irq40 level 6");
        cfg_irq(20, 1, 6);
        raise_irq(20, "R5 equal priority not taken");
        cfg_irq(50, 1, 7);
        raise_irq(50, "R5 higher than level taken");
        do_ack("R7 R10 nested ack level 7");
        do_ret("R9 nested return to 6");
        do_ret("R9 return to 0");
        do_ret("R9 return on empty stack ignored");

        // R9: acknowledge and return together, acknowledge served.
        begin
            int v, p;
            best(v, p);
            m_stk.push_back(m_lvl); m_lvl = p;
            m_irq[v-NT] = 1'b0;
            ack = 1'b1; ret = 1'b1;
            settle("R9 ack wins over return");
        end
        do_ret("R9 back to 0");
        do_ret("R9 empty again");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule